// File: doc/BRIEF.md
# Segmented SPI Master with Register Control

This block is a single SPI master driven by a CPU through a small register file. Software programs the clock polarity and phase, the bit order, half-duplex operation, the chip-select line mask and a per-line active-level mask, the transfer length and the clock divider. A write to the data register then starts a transfer of 1 to 32 bits. Outgoing data is taken left-justified from the written word. Incoming bits are shifted into a readable register from the right.

A segment-end flag decides what happens to chip select when a transfer finishes. It is either released, or held asserted so that the next data write continues the same bus transaction. Length and half-duplex mode may be reprogrammed between held segments. A command phase can therefore be followed by a read phase on the shared data line inside one chip-select window. Two status outputs tell software when a new word may be written and when no transaction is open. An offline bit parks every bus output at its inactive level.

Top module: `spi_seg_master`

## Requirements
- R1: The length register (address 2) holds the bit count minus one. A transfer produces exactly length+1 sampling clock edges.
- R2: The divider register (address 3) holds the SCLK ratio minus two. Consecutive sampling edges are divider+2 system clock cycles apart.
- R3: Transmit data is left-justified in the 32-bit word. With LSB-first (config bit 6) clear, bit 31 goes out first. With it set, the lowest bit of the field, bit 32-n, goes out first.
- R4: Received bits shift into the data register (address 0 on read) from bit 0, so the low bits hold the most recent input. In full-duplex the input is sdi_i.
- R5: Config bit 4 sets the SCLK idle level. Config bit 5 selects the phase: when it is clear, the sampling edge is the leading edge of each bit; when it is set, the sampling edge is the trailing edge.
- R6: With the end flag (config bit 1) set, chip select returns to inactive after the last bit. With it clear, chip select stays asserted, idle_o stays low and writable_o returns high.
- R7: writable_o is low during a transfer. A data write made while writable_o is low is ignored. idle_o is high only when no transfer runs and no chip select is held.
- R8: The select register (address 4) is a line mask. The polarity register (address 5) gives each line its active level (1 = active high). Unselected lines and all lines outside a transaction sit at their inactive level.
- R9: With half-duplex (config bit 7) set, sdo_oe_o stays low and input bits come from sdo_line_i. The bit may change between held segments.
- R10: With offline (config bit 0) set, SCLK sits at its idle level, sdo_oe_o is low, chip select is inactive, writable_o is low and data writes are ignored.
- R11: A one-bit transfer with an empty select mask produces one sampling edge while every chip-select line stays inactive.
- R12: After reset: writable_o=1, idle_o=1, sclk_o=0, sdo_oe_o=0, all chip-select lines high, and the data register reads 0.
- R13: The config register (address 1) reads back bits 0, 1 and 4 to 7 as written. Bits 2 and 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data, combinational on address |
| writable_o | output | 1 | A new data word may be written |
| idle_o | output | 1 | No transaction open |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the data-out line |
| sdo_line_i | input | 1 | Read-back of the data-out line, used in half-duplex |
| sdi_i | input | 1 | Serial data in |
| cs_o | output | NCS | Chip-select lines |

## Verification
Three functions can coincide: a segment finishing with chip select held, and software reprogramming length and half-duplex mode for the next segment. The bench provokes this with a 16-bit full-duplex command segment with the end flag clear. It then switches to an 8-bit half-duplex read with the end flag set. It checks that chip select never drops, that the drive enable stays low through the read, and that the data register holds the command bits followed by the bits read back from the data line. A second overlap is a data write that arrives while a transfer runs. This is judged by the edge count and the captured bits, which must match the first word only.

// File: rtl/spi_pkg.sv
package spi_pkg;
  typedef enum logic [2:0] {
    ADDR_DATA = 3'd0,
    ADDR_CFG  = 3'd1,
    ADDR_LEN  = 3'd2,
    ADDR_DIV  = 3'd3,
    ADDR_SEL  = 3'd4,
    ADDR_POL  = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic       half_duplex;
    logic       lsb_first;
    logic       cpha;
    logic       cpol;
    logic [1:0] unused;
    logic       end_seg;
    logic       offline;
  } spi_cfg_t;

  localparam logic [7:0] CFG_WMASK = 8'hF3;
endpackage

// File: rtl/spi_regs.sv
module spi_regs
  import spi_pkg::*;
#(
  parameter int DW   = 32,
  parameter int LW   = 5,
  parameter int DIVW = 8,
  parameter int NCS  = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [2:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   rx_i,
  output spi_cfg_t        cfg_o,
  output logic [LW-1:0]   len_o,
  output logic [DIVW-1:0] div_o,
  output logic [NCS-1:0]  sel_o,
  output logic [NCS-1:0]  pol_o,
  output logic [DW-1:0]   rdata_o,
  output logic            start_o
);
  spi_cfg_t        cfg_q;
  logic [LW-1:0]   len_q;
  logic [DIVW-1:0] div_q;
  logic [NCS-1:0]  sel_q, pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      len_q <= '0;
      div_q <= '0;
      sel_q <= '0;
      pol_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_CFG: cfg_q <= spi_cfg_t'(wdata_i[7:0] & CFG_WMASK);
        ADDR_LEN: len_q <= wdata_i[LW-1:0];
        ADDR_DIV: div_q <= wdata_i[DIVW-1:0];
        ADDR_SEL: sel_q <= wdata_i[NCS-1:0];
        ADDR_POL: pol_q <= wdata_i[NCS-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_DATA: rdata_o = rx_i;
      ADDR_CFG:  rdata_o[7:0] = cfg_q;
      ADDR_LEN:  rdata_o[LW-1:0] = len_q;
      ADDR_DIV:  rdata_o[DIVW-1:0] = div_q;
      ADDR_SEL:  rdata_o[NCS-1:0] = sel_q;
      ADDR_POL:  rdata_o[NCS-1:0] = pol_q;
      default:   rdata_o = '0;
    endcase
  end

  assign start_o = we_i && (addr_i == ADDR_DATA);
  assign cfg_o   = cfg_q;
  assign len_o   = len_q;
  assign div_o   = div_q;
  assign sel_o   = sel_q;
  assign pol_o   = pol_q;
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int DIVW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [DIVW-1:0] div_i,
  output logic            tick_o,
  output logic            half_o
);
  localparam int RW = DIVW + 1;

  logic [DIVW-1:0] div_l;
  logic [RW-1:0]   ratio, h_lo, h_hi, lim, cnt_q;
  logic            half_q;

  // odd ratios put the extra cycle in the second half
  assign ratio = {1'b0, div_l} + RW'(2);
  assign h_lo  = ratio >> 1;
  assign h_hi  = ratio - h_lo;
  assign lim   = half_q ? (h_hi - RW'(1)) : (h_lo - RW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
      div_l  <= '0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
      div_l  <= div_i;
    end else if (cnt_q == lim) begin
      cnt_q  <= '0;
      half_q <= ~half_q;
    end else begin
      cnt_q <= cnt_q + RW'(1);
    end
  end

  assign tick_o = en_i && (cnt_q == lim);
  assign half_o = half_q;
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_pkg::*;
#(
  parameter int DW  = 32,
  parameter int LW  = 5,
  parameter int NCS = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [DW-1:0]  tx_i,
  input  spi_cfg_t       cfg_i,
  input  logic [LW-1:0]  len_i,
  input  logic [NCS-1:0] sel_i,
  input  logic           tick_i,
  input  logic           half_i,
  input  logic           sdi_i,
  input  logic           sdo_line_i,
  output logic           busy_o,
  output logic           hold_o,
  output logic           sdo_o,
  output logic           sdo_oe_o,
  output logic           sclk_act_o,
  output logic [NCS-1:0] cs_act_o,
  output logic [DW-1:0]  rx_o
);
  logic [DW-1:0]  sr_q, rx_q;
  logic [LW-1:0]  bits_q;
  logic [NCS-1:0] sel_l;
  logic           busy_q, hold_q, cpha_l, lsb_l, hd_l, end_l;
  logic           go, in_bit;

  assign go     = start_i && !busy_q && !cfg_i.offline;
  assign in_bit = hd_l ? sdo_line_i : sdi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      hold_q <= 1'b0;
      sr_q   <= '0;
      rx_q   <= '0;
      bits_q <= '0;
      sel_l  <= '0;
      cpha_l <= 1'b0;
      lsb_l  <= 1'b0;
      hd_l   <= 1'b0;
      end_l  <= 1'b0;
    end else if (cfg_i.offline) begin
      busy_q <= 1'b0;
      hold_q <= 1'b0;
    end else if (go) begin
      busy_q <= 1'b1;
      hold_q <= 1'b1;
      bits_q <= len_i;
      // LSB-first: move the bottom of the left-justified field to bit 0
      sr_q   <= cfg_i.lsb_first ? (tx_i >> (LW'(DW-1) - len_i)) : tx_i;
      sel_l  <= sel_i;
      cpha_l <= cfg_i.cpha;
      lsb_l  <= cfg_i.lsb_first;
      hd_l   <= cfg_i.half_duplex;
      end_l  <= cfg_i.end_seg;
    end else if (busy_q && tick_i) begin
      if (!half_i) begin
        rx_q <= {rx_q[DW-2:0], in_bit};
      end else if (bits_q == '0) begin
        busy_q <= 1'b0;
        if (end_l) hold_q <= 1'b0;
      end else begin
        bits_q <= bits_q - LW'(1);
        sr_q   <= lsb_l ? (sr_q >> 1) : (sr_q << 1);
      end
    end
  end

  assign busy_o     = busy_q;
  assign hold_o     = hold_q;
  assign sdo_o      = busy_q && (lsb_l ? sr_q[0] : sr_q[DW-1]);
  assign sdo_oe_o   = busy_q && !hd_l;
  assign sclk_act_o = busy_q && (half_i ^ cpha_l);
  assign cs_act_o   = sel_l & {NCS{hold_q}};
  assign rx_o       = rx_q;
endmodule

// File: rtl/spi_seg_master.sv
module spi_seg_master
  import spi_pkg::*;
#(
  parameter int NCS  = 4,
  parameter int DW   = 32,
  parameter int DIVW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [2:0]      reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic            writable_o,
  output logic            idle_o,
  output logic            sclk_o,
  output logic            sdo_o,
  output logic            sdo_oe_o,
  input  logic            sdo_line_i,
  input  logic            sdi_i,
  output logic [NCS-1:0]  cs_o
);
  localparam int LW = $clog2(DW);

  spi_cfg_t        cfg;
  logic [LW-1:0]   len;
  logic [DIVW-1:0] div;
  logic [NCS-1:0]  sel, pol, cs_act;
  logic [DW-1:0]   rx;
  logic            start, busy, hold, tick, half;
  logic            sh_sdo, sh_oe, sclk_act;
  logic            offline, cpol, cfg_hd;

  assign offline = cfg.offline;
  assign cpol    = cfg.cpol;
  assign cfg_hd  = cfg.half_duplex;

  spi_regs #(.DW(DW), .LW(LW), .DIVW(DIVW), .NCS(NCS)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rx_i(rx), .cfg_o(cfg), .len_o(len), .div_o(div),
    .sel_o(sel), .pol_o(pol), .rdata_o(reg_rdata_o), .start_o(start)
  );

  spi_clkgen #(.DIVW(DIVW)) u_clk (
    .clk_i, .rst_ni, .en_i(busy), .div_i(div), .tick_o(tick), .half_o(half)
  );

  spi_shifter #(.DW(DW), .LW(LW), .NCS(NCS)) u_sh (
    .clk_i, .rst_ni,
    .start_i(start), .tx_i(reg_wdata_i), .cfg_i(cfg), .len_i(len), .sel_i(sel),
    .tick_i(tick), .half_i(half), .sdi_i(sdi_i), .sdo_line_i(sdo_line_i),
    .busy_o(busy), .hold_o(hold), .sdo_o(sh_sdo), .sdo_oe_o(sh_oe),
    .sclk_act_o(sclk_act), .cs_act_o(cs_act), .rx_o(rx)
  );

  assign sclk_o     = cpol ^ (sclk_act && !offline);
  assign sdo_o      = sh_sdo && !offline;
  assign sdo_oe_o   = sh_oe && !offline;
  assign cs_o       = ~pol ^ (cs_act & {NCS{!offline}});
  assign writable_o = !busy && !offline;
  assign idle_o     = !busy && !hold;
endmodule

// File: rtl/spi_seg_master_chk.sv
module spi_seg_master_chk #(
  parameter int NCS = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           writable_o,
  input logic           idle_o,
  input logic           sclk_o,
  input logic           sdo_oe_o,
  input logic [NCS-1:0] cs_o,
  input logic           busy,
  input logic           offline,
  input logic           cpol,
  input logic           cfg_hd,
  input logic [NCS-1:0] pol
);
  a_r7_busy_not_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!writable_o && !offline) |-> !idle_o);

  a_r10_offline_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offline |-> (!writable_o && !sdo_oe_o && (cs_o == ~pol) && (sclk_o == cpol)));

  a_r6_cs_steady_in_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy) && !offline && !$past(offline)) |-> $stable(cs_o));

  a_r9_hd_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy) && $past(cfg_hd)) |-> !sdo_oe_o);

  a_r5_sclk_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !$past(busy) && $stable(cpol)) |-> $stable(sclk_o));

  a_r8_idle_cs_inactive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (cs_o == ~pol));
endmodule

bind spi_seg_master spi_seg_master_chk #(.NCS(NCS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .writable_o(writable_o), .idle_o(idle_o),
  .sclk_o(sclk_o), .sdo_oe_o(sdo_oe_o), .cs_o(cs_o), .busy(busy),
  .offline(offline), .cpol(cpol), .cfg_hd(cfg_hd), .pol(pol)
);

// File: tb/tb_spi_seg_master.sv
module tb_spi_seg_master;
  localparam int NCS = 4;
  localparam int DW  = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          writable, idle, sclk, sdo, sdo_oe, sdi, sdo_line;
  logic [NCS-1:0] cs;

  always #5 clk = ~clk;

  assign sdi = sdo;  // loopback in full-duplex
  logic hd_line = 1'b0;
  assign sdo_line = hd_line;

  spi_seg_master #(.NCS(NCS), .DW(DW), .DIVW(8)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .writable_o(writable),
    .idle_o(idle), .sclk_o(sclk), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .sdo_line_i(sdo_line), .sdi_i(sdi), .cs_o(cs)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus monitor
  logic           cpol_b = 0, cpha_b = 0;
  logic [NCS-1:0] pol_b = '0;
  logic           sclk_prev = 0;
  logic [31:0]    mon_bits = 0;
  int             mon_cnt = 0, mon_per = 0, gap = 0;
  logic           mon_oe = 0;
  logic [NCS-1:0] mon_csact = '0;

  always @(negedge clk) begin
    gap = gap + 1;
    if (sclk !== sclk_prev && sclk === (cpol_b ^ ~cpha_b)) begin
      mon_bits = {mon_bits[30:0], sdo};
      if (mon_cnt > 0) mon_per = gap;
      gap = 0;
      mon_cnt = mon_cnt + 1;
      mon_oe = mon_oe | sdo_oe;
    end
    sclk_prev = sclk;
    mon_csact = mon_csact | (cs ^ ~pol_b);
  end

  task automatic arm();
    @(posedge clk); #1;
    mon_bits = 0; mon_cnt = 0; mon_per = 0; gap = 0; mon_oe = 0; mon_csact = '0;
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_done();
    int t = 0;
    @(negedge clk);
    while (!writable && t < 20000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 20000) check("R7 completion timeout", 0, 1);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_bits(input logic [31:0] d, input int n, input bit lsb);
    logic [31:0] r = 0;
    for (int i = 0; i < n; i++) r = {r[30:0], lsb ? d[32-n+i] : d[31-i]};
    return r;
  endfunction

  function automatic logic [31:0] mask_n(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  typedef struct packed {
    logic [7:0]  cfg;
    logic [4:0]  len;
    logic [7:0]  div;
    logic [31:0] data;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'h00, 5'd23, 8'd14, 32'hA5C3_F100},
    '{8'h20, 5'd7,  8'd0,  32'h9600_0000},
    '{8'h10, 5'd15, 8'd1,  32'h1234_0000},
    '{8'h30, 5'd31, 8'd2,  32'hDEAD_BEEF},
    '{8'h40, 5'd11, 8'd0,  32'hABC0_0000},
    '{8'h60, 5'd0,  8'd3,  32'h8000_0000}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd, rx_before;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 writable", writable, 1);
    check("R12 idle", idle, 1);
    check("R12 sclk", sclk, 0);
    check("R12 oe", sdo_oe, 0);
    check("R12 cs", cs, 4'hF);
    reg_rd(3'd0, rd);
    check("R12 data reg", rd, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R13 config readback
    reg_wr(3'd1, 32'hFC);
    reg_rd(3'd1, rd);
    check("R13 cfg readback", rd, 32'hF0);

    reg_wr(3'd4, 32'h1);
    reg_wr(3'd5, 32'h0);
    pol_b = '0;
    foreach (VECS[k]) begin
      int n;
      n = int'(VECS[k].len) + 1;
      cpol_b = VECS[k].cfg[4];
      cpha_b = VECS[k].cfg[5];
      reg_wr(3'd1, {24'h0, VECS[k].cfg | 8'h02});
      reg_wr(3'd2, {27'h0, VECS[k].len});
      reg_wr(3'd3, {24'h0, VECS[k].div});
      arm();
      reg_wr(3'd0, VECS[k].data);
      wait_done();
      check("R1 edge count", mon_cnt, n);
      check("R3 bit order", mon_bits & mask_n(n), exp_bits(VECS[k].data, n, VECS[k].cfg[6]));
      reg_rd(3'd0, rd);
      check("R4 rx right-aligned", rd & mask_n(n), exp_bits(VECS[k].data, n, VECS[k].cfg[6]));
      if (n > 1) check("R2 bit period", mon_per, int'(VECS[k].div) + 2);
      check("R5 sclk idle level", sclk, cpol_b);
      check("R6 cs released", cs, 4'hF);
      check("R7 idle after end", idle, 1);
    end

    // R6/R9 chained command + half-duplex read
    cpol_b = 0; cpha_b = 0;
    reg_wr(3'd1, 32'h00);
    reg_wr(3'd2, 32'd15);
    reg_wr(3'd3, 32'd2);
    reg_wr(3'd4, 32'b0010);
    arm();
    reg_wr(3'd0, 32'hC35A_0000);
    wait_done();
    check("R6 held cs", cs, 4'b1101);
    check("R6 idle low while held", idle, 0);
    check("R6 writable while held", writable, 1);
    reg_wr(3'd1, 32'h82);
    reg_wr(3'd2, 32'd7);
    hd_line = 1'b1;
    arm();
    reg_wr(3'd0, 32'h0);
    wait_done();
    check("R9 hd edge count", mon_cnt, 8);
    check("R9 oe low in hd", mon_oe, 0);
    check("R6 cs held through segments", mon_csact, 4'b0010);
    reg_rd(3'd0, rd);
    check("R9 hd capture", rd & 32'hFFFF, 32'h5AFF);
    check("R6 cs released after end", cs, 4'hF);
    hd_line = 1'b0;

    // R8 per-line polarity, R7 write while busy
    reg_wr(3'd1, 32'h02);
    reg_wr(3'd2, 32'd31);
    reg_wr(3'd3, 32'd14);
    reg_wr(3'd5, 32'b0101);
    reg_wr(3'd4, 32'b0100);
    pol_b = 4'b0101;
    @(negedge clk);
    check("R8 inactive levels", cs, 4'b1010);
    arm();
    reg_wr(3'd0, 32'h0F0F_0F0F);
    repeat (3) @(negedge clk);
    check("R8 active line", cs, 4'b1110);
    check("R7 writable low busy", writable, 0);
    check("R7 idle low busy", idle, 0);
    reg_wr(3'd0, 32'hFFFF_FFFF);
    wait_done();
    check("R7 busy write ignored count", mon_cnt, 32);
    check("R7 busy write ignored data", mon_bits, 32'h0F0F_0F0F);

    // R11 dummy one-bit cycle with no line selected
    reg_wr(3'd5, 32'h0);
    pol_b = '0;
    reg_wr(3'd4, 32'h0);
    reg_wr(3'd2, 32'd0);
    arm();
    reg_wr(3'd0, 32'h8000_0000);
    wait_done();
    check("R11 one edge", mon_cnt, 1);
    check("R11 cs never active", mon_csact, 4'h0);

    // R10 offline
    reg_wr(3'd4, 32'h1);
    reg_wr(3'd1, 32'h13);
    cpol_b = 1;
    @(negedge clk);
    check("R10 sclk idle", sclk, 1);
    check("R10 writable low", writable, 0);
    check("R10 cs inactive", cs, 4'hF);
    reg_rd(3'd0, rx_before);
    arm();
    reg_wr(3'd0, 32'h5555_5555);
    repeat (40) @(negedge clk);
    check("R10 no edges", mon_cnt, 0);
    check("R10 oe low", mon_oe, 0);
    check("R10 cs untouched", mon_csact, 4'h0);
    reg_rd(3'd0, rd);
    check("R10 rx unchanged", rd, rx_before);
    reg_wr(3'd1, 32'h02);
    @(negedge clk);
    check("R10 back online writable", writable, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule